// File: doc/BRIEF.md
# Two-Slot Power Controller Management Register Target

This block is the management-bus front end of a power controller that serves two card slots. A host on a shared two-wire bus (one clock line, one data line) uses it to set per-slot control bits, to read per-slot and shared status, and to see the logic level of two general-purpose inputs. The device address has seven bits. The upper four bits are fixed by a parameter. The lower three bits come from strap pins, so up to eight controllers can share one bus.

Two transaction shapes are recognised. A write sends the address with the direction bit low, then a command byte that selects a register, then a data byte. A receive sends the address with the direction bit high, and the target returns one byte from the register that the last command byte selected. A write that stops after the command byte only moves that selection. Both bus lines pass through a two-stage synchroniser and a three-sample agreement filter before any START, STOP or clock-edge decision is made.

Five registers exist. Codes 0 and 1 are the control registers of the first and second slot. Codes 2 and 3 are the status registers of the first and second slot. Code 4 is the shared status register. Every other code is reserved. The interrupt output is an open-drain pull. It is active while either slot has its interrupt-enable control bit set and any bit of that slot's status is set.

Top module: `dsmb_target`

## Requirements
- R1: After reset, `sda_pull`, `int_pull`, `ctl_a_out` and `ctl_b_out` are all zero, and the command pointer selects code 0.
- R2: The target acknowledges (pulls SDA low in the ninth clock) only the address whose upper four bits equal `BASE_ADDR` and whose lower three bits equal `addr_strap`. For any other address it does not acknowledge, and it ignores the rest of the transaction, so no register changes.
- R3: In a write, the address byte, the command byte and the data byte are each acknowledged. A data byte sent to code 0 or code 1 loads bits 5:0 of that byte into `ctl_a_out` or `ctl_b_out`.
- R4: A receive returns, most significant bit first, the register selected by the most recent command byte. The target releases SDA after the eighth bit.
- R5: A write that ends with STOP right after the command byte changes the pointer and writes no register.
- R6: A write to a reserved code (greater than 4) changes nothing, and a receive from a reserved code returns 0x00.
- R7: Bits 7:6 of a control register cannot be written. On a read they return bits 1:0 of the same slot's status input.
- R8: Codes 2 and 3 read back `stat_a_in` and `stat_b_in`. Writes to these codes change nothing.
- R9: Code 4 reads as {2'b00, gpi[1:0], com_flags_in[3:0]}, where `gpi` is `gpi_in` after a two-flop synchroniser.
- R10: One clock after its inputs change, `int_pull` equals (ctl_a bit 5 AND any bit of `stat_a_in`) OR (ctl_b bit 5 AND any bit of `stat_b_in`).
- R11: A low pulse of two system clocks or fewer on SCL while SCL is high is filtered out and does not disturb the byte being received.
- R12: A STOP in the middle of a data byte ends the transaction with no register write and with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull the data line low |
| addr_strap | input | 3 | Lower three bits of the device address |
| gpi_in | input | 2 | General-purpose inputs, asynchronous |
| stat_a_in | input | 8 | Status bits of the first slot |
| stat_b_in | input | 8 | Status bits of the second slot |
| com_flags_in | input | 4 | Shared status flags |
| ctl_a_out | output | 6 | Writable control bits of the first slot |
| ctl_b_out | output | 6 | Writable control bits of the second slot |
| int_pull | output | 1 | 1 = pull the interrupt line low |

## Verification
A change on a raw bus line reaches the decision logic about six system clocks later: two synchroniser stages, the three-sample filter and the previous-value register used for edge detection. Acknowledge and read-data bits therefore change about six clocks after the raw SCL falling edge. The bench holds each SCL phase for at least eight clocks and samples SDA in the middle of the high phase. Control outputs are compared against the bench model on every clock while the bus is idle; the model takes each write only after the closing STOP has settled. `int_pull` is compared every clock against a value the model computes one clock earlier, which matches its single register stage.

// File: rtl/dsmb_pkg.sv
package dsmb_pkg;

    localparam int BYTE_W       = 8;
    localparam int NSLOT        = 2;
    localparam int CTL_WR_BITS  = 6;
    localparam int CTL_RO_BITS  = BYTE_W - CTL_WR_BITS;
    localparam int INT_EN_BIT   = 5;
    localparam int SYNC_STAGES  = 2;
    localparam int FILT_LEN     = 3;
    localparam int GPI_W        = 2;
    localparam int FLAG_W       = 4;

    localparam logic [BYTE_W-1:0] CMD_CTL_A  = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_CTL_B  = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_STAT_A = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_STAT_B = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_COMMON = 8'h04;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_AACK,
        BS_WRX,
        BS_WACK,
        BS_RDX,
        BS_RACK,
        BS_SKIP
    } bus_st_e;

    typedef struct packed {
        logic              cmd_stb;
        logic              data_stb;
        logic [BYTE_W-1:0] byte_val;
    } wr_evt_t;

    function automatic logic cmd_reserved(input logic [BYTE_W-1:0] code);
        return code > CMD_COMMON;
    endfunction

    function automatic logic [BYTE_W-1:0] common_word(input logic [GPI_W-1:0] gpi,
                                                      input logic [FLAG_W-1:0] flags);
        return {{(BYTE_W-GPI_W-FLAG_W){1'b0}}, gpi, flags};
    endfunction

endpackage

// File: rtl/dsmb_line_filter.sv
module dsmb_line_filter
    import dsmb_pkg::*;
#(
    parameter int SYNC = SYNC_STAGES,
    parameter int FLEN = FILT_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);

    logic [SYNC-1:0] sync_q;
    logic [FLEN-1:0] hist_q;
    logic            filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], raw};
            hist_q <= {hist_q[FLEN-2:0], sync_q[SYNC-1]};
            if (&hist_q)
                filt_q <= 1'b1;
            else if (~|hist_q)
                filt_q <= 1'b0;
        end
    end

    assign filt = filt_q;

endmodule

// File: rtl/dsmb_bus_engine.sv
module dsmb_bus_engine
    import dsmb_pkg::*;
#(
    parameter logic [3:0] BASE_ADDR = 4'b1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output wr_evt_t           evt,
    output logic              sda_pull,
    output logic              active,
    output logic              stop_seen
);

    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

    bus_st_e           st_q;
    logic              scl_q, sda_q;
    logic [BYTE_W-1:0] sh_q;
    logic [3:0]        bitc_q;
    logic [1:0]        bidx_q;
    logic              rw_q, mack_q, pull_q;
    wr_evt_t           evt_q;

    logic start_c, stop_c, rise_c, fall_c, addr_hit;

    assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
    assign rise_c   = scl_f & ~scl_q;
    assign fall_c   = ~scl_f & scl_q;
    assign addr_hit = (sh_q[BYTE_W-1:1] == {BASE_ADDR, strap});

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BS_IDLE;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            sh_q   <= '0;
            bitc_q <= '0;
            bidx_q <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            pull_q <= 1'b0;
            evt_q  <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            evt_q <= '0;
            if (start_c) begin
                st_q   <= BS_ADDR;
                bitc_q <= '0;
                pull_q <= 1'b0;
            end else if (stop_c) begin
                st_q   <= BS_IDLE;
                pull_q <= 1'b0;
            end else begin
                unique case (st_q)
                    BS_ADDR, BS_WRX: begin
                        if (rise_c) begin
                            sh_q   <= {sh_q[BYTE_W-2:0], sda_f};
                            bitc_q <= bitc_q + 4'd1;
                        end else if (fall_c && bitc_q == BITS_PER_BYTE) begin
                            bitc_q <= '0;
                            if (st_q == BS_ADDR) begin
                                if (addr_hit) begin
                                    pull_q <= 1'b1;
                                    rw_q   <= sh_q[0];
                                    bidx_q <= '0;
                                    st_q   <= BS_AACK;
                                end else begin
                                    st_q <= BS_SKIP;
                                end
                            end else if (bidx_q < 2'd2) begin
                                pull_q          <= 1'b1;
                                evt_q.cmd_stb   <= (bidx_q == 2'd0);
                                evt_q.data_stb  <= (bidx_q == 2'd1);
                                evt_q.byte_val  <= sh_q;
                                bidx_q          <= bidx_q + 2'd1;
                                st_q            <= BS_WACK;
                            end else begin
                                st_q <= BS_SKIP;
                            end
                        end
                    end
                    BS_AACK: begin
                        if (fall_c) begin
                            bitc_q <= '0;
                            if (rw_q) begin
                                sh_q   <= rd_byte;
                                pull_q <= ~rd_byte[BYTE_W-1];
                                st_q   <= BS_RDX;
                            end else begin
                                pull_q <= 1'b0;
                                st_q   <= BS_WRX;
                            end
                        end
                    end
                    BS_WACK: begin
                        if (fall_c) begin
                            pull_q <= 1'b0;
                            st_q   <= BS_WRX;
                        end
                    end
                    BS_RDX: begin
                        if (rise_c) begin
                            bitc_q <= bitc_q + 4'd1;
                        end else if (fall_c) begin
                            if (bitc_q == BITS_PER_BYTE) begin
                                pull_q <= 1'b0;
                                st_q   <= BS_RACK;
                            end else begin
                                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                                pull_q <= ~sh_q[BYTE_W-2];
                            end
                        end
                    end
                    BS_RACK: begin
                        if (rise_c) begin
                            mack_q <= ~sda_f;
                        end else if (fall_c) begin
                            if (mack_q) begin
                                sh_q   <= rd_byte;
                                pull_q <= ~rd_byte[BYTE_W-1];
                                bitc_q <= '0;
                                st_q   <= BS_RDX;
                            end else begin
                                st_q <= BS_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign evt       = evt_q;
    assign sda_pull  = pull_q;
    assign active    = (st_q != BS_IDLE);
    assign stop_seen = stop_c;

endmodule

// File: rtl/dsmb_regbank.sv
module dsmb_regbank
    import dsmb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  wr_evt_t                evt,
    input  logic [GPI_W-1:0]       gpi_raw,
    input  logic [BYTE_W-1:0]      stat_a,
    input  logic [BYTE_W-1:0]      stat_b,
    input  logic [FLAG_W-1:0]      flags,
    output logic [BYTE_W-1:0]      rd_byte,
    output logic [CTL_WR_BITS-1:0] ctl_a,
    output logic [CTL_WR_BITS-1:0] ctl_b,
    output logic                   int_pull,
    output logic                   ptr_rsv
);

    logic [BYTE_W-1:0]      ptr_q;
    logic [GPI_W-1:0]       gpi_s1_q, gpi_s2_q;
    logic                   int_q;
    logic [CTL_WR_BITS-1:0] ctl_w  [NSLOT];
    logic [BYTE_W-1:0]      stat_w [NSLOT];
    logic [NSLOT-1:0]       irq_v;

    assign stat_w[0] = stat_a;
    assign stat_w[1] = stat_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= CMD_CTL_A;
            gpi_s1_q <= '0;
            gpi_s2_q <= '0;
            int_q    <= 1'b0;
        end else begin
            if (evt.cmd_stb)
                ptr_q <= evt.byte_val;
            gpi_s1_q <= gpi_raw;
            gpi_s2_q <= gpi_s1_q;
            int_q    <= |irq_v;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [CTL_WR_BITS-1:0] ctl_r;
        always_ff @(posedge clk) begin
            if (rst)
                ctl_r <= '0;
            else if (evt.data_stb && ptr_q == 8'(s))
                ctl_r <= evt.byte_val[CTL_WR_BITS-1:0];
        end
        assign ctl_w[s] = ctl_r;
        assign irq_v[s] = ctl_r[INT_EN_BIT] & (|stat_w[s]);
    end

    always_comb begin
        unique case (ptr_q)
            CMD_CTL_A:  rd_byte = {stat_w[0][CTL_RO_BITS-1:0], ctl_w[0]};
            CMD_CTL_B:  rd_byte = {stat_w[1][CTL_RO_BITS-1:0], ctl_w[1]};
            CMD_STAT_A: rd_byte = stat_w[0];
            CMD_STAT_B: rd_byte = stat_w[1];
            CMD_COMMON: rd_byte = common_word(gpi_s2_q, flags);
            default:    rd_byte = '0;
        endcase
    end

    assign ctl_a    = ctl_w[0];
    assign ctl_b    = ctl_w[1];
    assign int_pull = int_q;
    assign ptr_rsv  = cmd_reserved(ptr_q);

endmodule

// File: rtl/dsmb_target.sv
module dsmb_target
    import dsmb_pkg::*;
#(
    parameter logic [3:0] BASE_ADDR = 4'b1000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_pull,
    input  logic [2:0]             addr_strap,
    input  logic [GPI_W-1:0]       gpi_in,
    input  logic [BYTE_W-1:0]      stat_a_in,
    input  logic [BYTE_W-1:0]      stat_b_in,
    input  logic [FLAG_W-1:0]      com_flags_in,
    output logic [CTL_WR_BITS-1:0] ctl_a_out,
    output logic [CTL_WR_BITS-1:0] ctl_b_out,
    output logic                   int_pull
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic [BYTE_W-1:0] rd_byte_w;
    wr_evt_t           evt_w;
    logic              eng_active, stop_det, ptr_rsv_w, data_stb_w;

    assign raw_lines = {sda_in, scl_in};

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        dsmb_line_filter #(.SYNC(SYNC_STAGES), .FLEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[l]),
            .filt (filt_lines[l])
        );
    end

    dsmb_bus_engine #(.BASE_ADDR(BASE_ADDR)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .scl_f     (filt_lines[0]),
        .sda_f     (filt_lines[1]),
        .strap     (addr_strap),
        .rd_byte   (rd_byte_w),
        .evt       (evt_w),
        .sda_pull  (sda_pull),
        .active    (eng_active),
        .stop_seen (stop_det)
    );

    dsmb_regbank u_regs (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_w),
        .gpi_raw  (gpi_in),
        .stat_a   (stat_a_in),
        .stat_b   (stat_b_in),
        .flags    (com_flags_in),
        .rd_byte  (rd_byte_w),
        .ctl_a    (ctl_a_out),
        .ctl_b    (ctl_b_out),
        .int_pull (int_pull),
        .ptr_rsv  (ptr_rsv_w)
    );

    assign data_stb_w = evt_w.data_stb;

endmodule

// File: rtl/dsmb_target_chk.sv
module dsmb_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       sda_pull,
    input logic       int_pull,
    input logic [5:0] ctl_a_out,
    input logic [5:0] ctl_b_out,
    input logic [7:0] stat_a_in,
    input logic [7:0] stat_b_in,
    input logic       eng_active,
    input logic       data_stb_w,
    input logic       ptr_rsv_w,
    input logic       stop_det
);

    // R1: outputs quiet right after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_pull && !int_pull && ctl_a_out == 6'd0 && ctl_b_out == 6'd0));

    // R10: interrupt follows enabled status one clock later
    a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
        int_pull == $past((ctl_a_out[5] && (|stat_a_in)) || (ctl_b_out[5] && (|stat_b_in))));

    // R2: data line is only pulled inside a transaction
    a_r2_pull_in_txn: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> eng_active);

    // R6: data strobe to a reserved code leaves control registers alone
    a_r6_reserved_inert: assert property (@(posedge clk) disable iff (rst)
        (data_stb_w && ptr_rsv_w) |=> ($stable(ctl_a_out) && $stable(ctl_b_out)));

    // R12: a STOP releases the data line
    a_r12_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_pull);

endmodule

bind dsmb_target dsmb_target_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull   (sda_pull),
    .int_pull   (int_pull),
    .ctl_a_out  (ctl_a_out),
    .ctl_b_out  (ctl_b_out),
    .stat_a_in  (stat_a_in),
    .stat_b_in  (stat_b_in),
    .eng_active (eng_active),
    .data_stb_w (data_stb_w),
    .ptr_rsv_w  (ptr_rsv_w),
    .stop_det   (stop_det)
);

// File: tb/dsmb_target_bench.sv
module dsmb_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [6:0] MY_ADDR    = 7'h45;
    localparam logic [6:0] OTHER_ADDR = 7'h44;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [1:0] gpi = 2'b00;
    logic [7:0] stat_a = 8'h00;
    logic [7:0] stat_b = 8'h00;
    logic [3:0] flags = 4'h0;
    logic       sda_pull, int_pull;
    logic [5:0] ctl_a_out, ctl_b_out;
    wire        sda_line = sda_h & ~sda_pull;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  chk_en = 1'b0;
    bit  done = 1'b0;
    logic [7:0] m_ptr = 8'h00;
    logic [5:0] m_ctl [2];
    logic       exp_int = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsmb_target u_dsmb_target (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_h),
        .sda_in       (sda_line),
        .sda_pull     (sda_pull),
        .addr_strap   (3'b101),
        .gpi_in       (gpi),
        .stat_a_in    (stat_a),
        .stat_b_in    (stat_b),
        .com_flags_in (flags),
        .ctl_a_out    (ctl_a_out),
        .ctl_b_out    (ctl_b_out),
        .int_pull     (int_pull)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] p);
        case (p)
            8'h00:   return {stat_a[1:0], m_ctl[0]};
            8'h01:   return {stat_b[1:0], m_ctl[1]};
            8'h02:   return stat_a;
            8'h03:   return stat_b;
            8'h04:   return {2'b00, gpi, flags};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [7:0] p, input logic [7:0] d);
        if (p == 8'h00) m_ctl[0] = d[5:0];
        else if (p == 8'h01) m_ctl[1] = d[5:0];
    endtask

    // reference interrupt: registered view of the model
    always @(posedge clk)
        exp_int <= rst ? 1'b0 :
                   ((m_ctl[0][5] && (|stat_a)) || (m_ctl[1][5] && (|stat_b)));

    // per-clock comparison while the bus is idle
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R3 ctl_a per-clock", {2'b00, ctl_a_out}, {2'b00, m_ctl[0]});
            chk("R3 ctl_b per-clock", {2'b00, ctl_b_out}, {2'b00, m_ctl[1]});
            chk("R10 int per-clock", {7'd0, int_pull}, {7'd0, exp_int});
            chk("R12 sda idle release", {7'd0, sda_pull}, 8'h00);
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl_h = 1'b1; wt(Q);
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        wt(Q); sda_h = 1'b0; wt(Q);
        scl_h = 1'b1; wt(Q);
        sda_h = 1'b1; wt(2*Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        wt(Q); sda_h = b; wt(Q);
        scl_h = 1'b1;
        if (glitch) begin
            wt(4); scl_h = 1'b0; wt(2); scl_h = 1'b1; wt(2*Q-6);
        end else begin
            wt(2*Q);
        end
        scl_h = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gl_bit, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], i == gl_bit);
        sda_h = 1'b1; wt(2*Q);
        scl_h = 1'b1; wt(Q);
        ack = sda_line; wt(Q);
        scl_h = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; wt(2*Q);
            scl_h = 1'b1; wt(Q);
            b[i] = sda_line; wt(Q);
            scl_h = 1'b0;
        end
        send_bit(1'b1, 1'b0);
    endtask

    task automatic settle_model_on();
        wt(4);
    endtask

    task automatic txn_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                             input bit with_data, input int gl_bit, input bit exp_hit);
        logic ack;
        chk_en = 1'b0;
        bus_start();
        send_byte({a, 1'b0}, -1, ack);
        if (exp_hit) chk("R3 address ACK", {7'd0, ack}, 8'h00);
        else         chk("R2 foreign address NACK", {7'd0, ack}, 8'h01);
        send_byte(c, -1, ack);
        if (exp_hit) chk("R3 command ACK", {7'd0, ack}, 8'h00);
        if (with_data) begin
            send_byte(d, gl_bit, ack);
            if (exp_hit) chk("R3 data ACK", {7'd0, ack}, 8'h00);
        end
        bus_stop();
        wt(4);
        if (exp_hit) begin
            m_ptr = c;
            if (with_data) m_write(c, d);
        end
        wt(3);
        chk_en = 1'b1;
    endtask

    task automatic txn_read(input string tag, input logic [7:0] expv);
        logic ack;
        logic [7:0] got;
        chk_en = 1'b0;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, -1, ack);
        chk("R4 read address ACK", {7'd0, ack}, 8'h00);
        recv_byte(got);
        bus_stop();
        wt(4);
        chk_en = 1'b1;
        chk(tag, got, expv);
    endtask

    initial begin
        m_ctl[0] = 6'd0;
        m_ctl[1] = 6'd0;
        wt(6);
        rst = 1'b0;
        wt(1);
        // R1 reset state
        chk("R1 ctl_a reset", {2'b00, ctl_a_out}, 8'h00);
        chk("R1 ctl_b reset", {2'b00, ctl_b_out}, 8'h00);
        chk("R1 sda reset", {7'd0, sda_pull}, 8'h00);
        chk("R1 int reset", {7'd0, int_pull}, 8'h00);
        txn_read("R1 pointer selects code 0", 8'h00);
        chk_en = 1'b1;
        wt(4);

        // R3 / R4 write then read back slot A control
        txn_write(MY_ADDR, 8'h00, 8'h1B, 1'b1, -1, 1'b1);
        chk("R3 ctl_a written", {2'b00, ctl_a_out}, 8'h1B);
        txn_read("R4 read ctl_a", m_read(m_ptr));

        // R5 command-only write moves pointer
        txn_write(MY_ADDR, 8'h01, 8'h00, 1'b0, -1, 1'b1);
        txn_read("R5 pointer moved to ctl_b", m_read(8'h01));
        chk("R5 ctl_a untouched", {2'b00, ctl_a_out}, 8'h1B);

        // R7 read-only upper bits, R10 interrupt
        txn_write(MY_ADDR, 8'h00, 8'hFF, 1'b1, -1, 1'b1);
        chk("R7 writable bits only", {2'b00, ctl_a_out}, 8'h3F);
        stat_a = 8'h02;
        wt(3);
        chk("R10 int asserts", {7'd0, int_pull}, 8'h01);
        txn_read("R7 upper bits from status", 8'hBF);

        // R8 status registers
        txn_write(MY_ADDR, 8'h02, 8'h55, 1'b1, -1, 1'b1);
        txn_read("R8 stat_a readback", 8'h02);
        stat_b = 8'hC4;
        txn_write(MY_ADDR, 8'h03, 8'h00, 1'b0, -1, 1'b1);
        txn_read("R8 stat_b readback", 8'hC4);

        // R9 common status
        gpi = 2'b10; flags = 4'h9;
        wt(6);
        txn_write(MY_ADDR, 8'h04, 8'h00, 1'b0, -1, 1'b1);
        txn_read("R9 common gpi=10", 8'h29);
        gpi = 2'b01;
        wt(6);
        txn_read("R9 common gpi=01", 8'h19);

        // R6 reserved code
        txn_write(MY_ADDR, 8'h07, 8'hAA, 1'b1, -1, 1'b1);
        chk("R6 reserved write inert a", {2'b00, ctl_a_out}, 8'h3F);
        chk("R6 reserved write inert b", {2'b00, ctl_b_out}, 8'h00);
        txn_read("R6 reserved reads zero", 8'h00);

        // R2 foreign address ignored
        txn_write(OTHER_ADDR, 8'h00, 8'h00, 1'b1, -1, 1'b0);
        chk("R2 foreign write ignored", {2'b00, ctl_a_out}, 8'h3F);
        txn_read("R2 pointer kept after foreign txn", 8'h00);

        // R11 SCL glitch while a data bit is high
        txn_write(MY_ADDR, 8'h01, 8'h21, 1'b1, 3, 1'b1);
        chk("R11 glitch filtered", {2'b00, ctl_b_out}, 8'h21);
        stat_b = 8'h10;
        wt(3);
        chk("R10 int from slot b", {7'd0, int_pull}, 8'h01);
        stat_a = 8'h00;
        txn_write(MY_ADDR, 8'h01, 8'h01, 1'b1, -1, 1'b1);
        chk("R10 int masked", {7'd0, int_pull}, 8'h00);

        // R12 STOP inside data byte
        begin
            logic ack;
            chk_en = 1'b0;
            bus_start();
            send_byte({MY_ADDR, 1'b0}, -1, ack);
            send_byte(8'h00, -1, ack);
            chk("R12 command ACK before abort", {7'd0, ack}, 8'h00);
            for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
            bus_stop();
            wt(4);
            m_ptr = 8'h00;
            chk("R12 sda released", {7'd0, sda_pull}, 8'h00);
            chk_en = 1'b1;
            wt(3);
        end
        chk("R12 no write on abort", {2'b00, ctl_a_out}, 8'h3F);
        txn_read("R12 readback after abort", m_read(8'h00));

        wt(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, R1 run incomplete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule